// File: doc/BRIEF.md
# Multithreaded Retire Thread Selector

This block decides, every cycle, which hardware thread of a multithreaded core may retire its oldest instruction next. For each thread it looks at whether the thread is active and what state it is in. It also looks at whether that thread's reorder buffer is empty, whether the buffer's head entry is ready, and the sequence number of that head entry. From these inputs it produces a single grant: a valid flag and a thread index. The retire logic that consumes the grant accepts it with a ready strobe. A grant is taken when valid and ready are both high at a clock edge. The grant is a combinational function of the current inputs and the stored priority order. It may change from cycle to cycle whenever the inputs change, and holding ready low only stops the priority order from moving.

A static mode input chooses the policy. In round-robin mode a registered priority order of all thread indices is scanned from the front. The first eligible thread wins, and a taken grant moves that thread to the back of the order. In oldest-first mode the eligible thread whose head carries the smallest sequence number wins. The burst mode uses the same selection rule as oldest-first; it exists so the retire stage can call the selector for several slots in one cycle. A build with a single thread reduces the block to a status check on that thread.

Top module: `thr_retire_sel`

## Requirements
- R1: `sel_mode` encoding: 0 = burst, 1 = round-robin, 2 and 3 = oldest-first. Burst and code 3 select exactly as oldest-first.
- R2: In round-robin mode a thread is eligible when it is active, its head is ready, and its status is 0 (idle) or 1 (running). The priority order is scanned from position 0 upward, and the first eligible thread is granted.
- R3: A round-robin grant is taken when `grant_valid` and `grant_ready` are both high at a clock edge in mode 1. On that edge the granted thread leaves its position and is placed at the last position, and the threads behind it each move forward one place. In every other cycle the order is unchanged.
- R4: Reset sets the priority order to 0, 1, ..., N-1 from front to back. The order always holds each thread index exactly once.
- R5: In oldest-first mode a thread is eligible when it is active, its buffer is non-empty, its head is ready, and its status is 0, 1 or 3 (fetch-trap pending). Among the eligible threads, the one with the smallest head sequence number is granted.
- R6: When two eligible threads have equal head sequence numbers in oldest-first mode, the lower thread index wins.
- R7: When no thread is eligible, `grant_valid` is low and `grant_tid` is 0.
- R8: With one thread configured, thread 0 is granted whenever it is active and its status is 0, 1 or 3. Head readiness, buffer emptiness and mode are ignored in that build.
- R9: Status 2 (trap pending), status 4 (buffer squashing) and codes 5 to 7 never make a thread eligible in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_mode | input | 2 | Selection policy, static in operation |
| thr_active | input | NUM_THR | Thread is active |
| thr_status | input | 3*NUM_THR | Per-thread status code, thread i in bits [3i+2:3i] |
| rob_empty | input | NUM_THR | Thread's reorder buffer is empty |
| head_ready | input | NUM_THR | Thread's buffer head can retire |
| head_seq | input | SEQ_W*NUM_THR | Head sequence number, thread i in bits [SEQ_W*i+SEQ_W-1:SEQ_W*i] |
| grant_valid | output | 1 | A thread is granted |
| grant_tid | output | TID_W | Granted thread index, 0 when not valid |
| grant_ready | input | 1 | Retire stage takes the grant |

## Verification
The properties assume that `sel_mode` changes only while reset is held. They also assume that the status, readiness and sequence inputs are settled before each clock edge; each such input is a single per-thread value, and any of its codes is legal. The stimulus honours this by driving every input at the falling edge and by changing the mode only inside a reset pulse. Random status codes include the unused values 5 to 7. Narrow 8-bit sequence numbers make equal-age ties frequent, and directed steps cover the empty-buffer and single-thread cases.

// File: rtl/thr_retire_sel_pkg.sv
package thr_retire_sel_pkg;

  localparam int ST_W = 3;

  localparam logic [ST_W-1:0] ST_IDLE   = 3'd0;
  localparam logic [ST_W-1:0] ST_RUN    = 3'd1;
  localparam logic [ST_W-1:0] ST_TRAP   = 3'd2;
  localparam logic [ST_W-1:0] ST_FTRAP  = 3'd3;
  localparam logic [ST_W-1:0] ST_SQUASH = 3'd4;

  localparam logic [1:0] MODE_BURST = 2'd0;
  localparam logic [1:0] MODE_RR    = 2'd1;
  localparam logic [1:0] MODE_OLD   = 2'd2;

  // states that allow a round-robin grant
  function automatic logic rr_status_ok(input logic [ST_W-1:0] s);
    return (s == ST_IDLE) || (s == ST_RUN);
  endfunction

  // states that allow an oldest-first grant
  function automatic logic old_status_ok(input logic [ST_W-1:0] s);
    return (s == ST_IDLE) || (s == ST_RUN) || (s == ST_FTRAP);
  endfunction

endpackage

// File: rtl/thr_prio_order.sv
module thr_prio_order #(
  parameter int NUM_THR = 4,
  parameter int TID_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rotate,
  input  logic [TID_W-1:0]         rot_pos,
  output logic [NUM_THR*TID_W-1:0] order_flat
);

  logic [TID_W-1:0] ord_q [NUM_THR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_THR; i++) ord_q[i] <= TID_W'(i);
    end else if (rotate) begin
      for (int i = 0; i < NUM_THR - 1; i++) begin
        if (i >= int'(rot_pos)) ord_q[i] <= ord_q[i+1];
      end
      ord_q[NUM_THR-1] <= ord_q[rot_pos];
    end
  end

  for (genvar g = 0; g < NUM_THR; g++) begin : g_flat
    assign order_flat[g*TID_W +: TID_W] = ord_q[g];
  end

endmodule

// File: rtl/thr_rr_scan.sv
module thr_rr_scan #(
  parameter int NUM_THR = 4,
  parameter int TID_W   = 2
) (
  input  logic [NUM_THR*TID_W-1:0] order_flat,
  input  logic [NUM_THR-1:0]       elig,
  output logic                     hit,
  output logic [TID_W-1:0]         tid,
  output logic [TID_W-1:0]         pos
);

  // scan from the back so the front-most eligible entry is the last writer
  always_comb begin
    logic [TID_W-1:0] t;
    hit = 1'b0;
    tid = '0;
    pos = '0;
    for (int p = NUM_THR - 1; p >= 0; p--) begin
      t = order_flat[p*TID_W +: TID_W];
      if (elig[t]) begin
        hit = 1'b1;
        tid = t;
        pos = TID_W'(p);
      end
    end
  end

endmodule

// File: rtl/thr_old_scan.sv
module thr_old_scan #(
  parameter int NUM_THR = 4,
  parameter int SEQ_W   = 16,
  parameter int TID_W   = 2
) (
  input  logic [NUM_THR-1:0]       elig,
  input  logic [NUM_THR*SEQ_W-1:0] seq_flat,
  output logic                     hit,
  output logic [TID_W-1:0]         tid
);

  // strict less-than keeps the lower index on equal sequence numbers
  always_comb begin
    logic [SEQ_W-1:0] best;
    logic [SEQ_W-1:0] cur;
    hit  = 1'b0;
    tid  = '0;
    best = '0;
    for (int i = 0; i < NUM_THR; i++) begin
      cur = seq_flat[i*SEQ_W +: SEQ_W];
      if (elig[i] && (!hit || (cur < best))) begin
        hit  = 1'b1;
        tid  = TID_W'(i);
        best = cur;
      end
    end
  end

endmodule

// File: rtl/thr_retire_sel.sv
module thr_retire_sel #(
  parameter int NUM_THR = 4,
  parameter int SEQ_W   = 16,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               sel_mode,
  input  logic [NUM_THR-1:0]       thr_active,
  input  logic [3*NUM_THR-1:0]     thr_status,
  input  logic [NUM_THR-1:0]       rob_empty,
  input  logic [NUM_THR-1:0]       head_ready,
  input  logic [SEQ_W*NUM_THR-1:0] head_seq,
  output logic                     grant_valid,
  output logic [TID_W-1:0]         grant_tid,
  input  logic                     grant_ready
);
  import thr_retire_sel_pkg::*;

  logic [NUM_THR*TID_W-1:0] order_flat;

  if (NUM_THR == 1) begin : g_single
    assign grant_valid = thr_active[0] && old_status_ok(thr_status[2:0]);
    assign grant_tid   = '0;
    assign order_flat  = '0;
  end else begin : g_multi
    logic [NUM_THR-1:0] rr_elig;
    logic [NUM_THR-1:0] old_elig;
    logic               rr_hit;
    logic               old_hit;
    logic [TID_W-1:0]   rr_tid;
    logic [TID_W-1:0]   rr_pos;
    logic [TID_W-1:0]   old_tid;
    logic               is_rr;
    logic               take_rr;

    always_comb begin
      for (int i = 0; i < NUM_THR; i++) begin
        rr_elig[i]  = thr_active[i] && head_ready[i] &&
                      rr_status_ok(thr_status[i*ST_W +: ST_W]);
        old_elig[i] = thr_active[i] && head_ready[i] && !rob_empty[i] &&
                      old_status_ok(thr_status[i*ST_W +: ST_W]);
      end
    end

    thr_rr_scan #(.NUM_THR(NUM_THR), .TID_W(TID_W)) u_rr (
      .order_flat (order_flat),
      .elig       (rr_elig),
      .hit        (rr_hit),
      .tid        (rr_tid),
      .pos        (rr_pos)
    );

    thr_old_scan #(.NUM_THR(NUM_THR), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_old (
      .elig     (old_elig),
      .seq_flat (head_seq),
      .hit      (old_hit),
      .tid      (old_tid)
    );

    assign is_rr       = (sel_mode == MODE_RR);
    assign grant_valid = is_rr ? rr_hit : old_hit;
    assign grant_tid   = is_rr ? rr_tid : old_tid;
    assign take_rr     = is_rr && rr_hit && grant_ready;

    thr_prio_order #(.NUM_THR(NUM_THR), .TID_W(TID_W)) u_order (
      .clk        (clk),
      .rst_n      (rst_n),
      .rotate     (take_rr),
      .rot_pos    (rr_pos),
      .order_flat (order_flat)
    );
  end

endmodule

// File: rtl/thr_retire_sel_chk.sv
module thr_retire_sel_chk #(
  parameter int NUM_THR = 4,
  parameter int SEQ_W   = 16,
  parameter int TID_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               sel_mode,
  input logic [NUM_THR-1:0]       thr_active,
  input logic [3*NUM_THR-1:0]     thr_status,
  input logic [NUM_THR-1:0]       rob_empty,
  input logic [NUM_THR-1:0]       head_ready,
  input logic                     grant_valid,
  input logic [TID_W-1:0]         grant_tid,
  input logic                     grant_ready,
  input logic [NUM_THR*TID_W-1:0] order_flat
);

  logic [2:0]         g_st;
  logic [NUM_THR-1:0] seen;

  assign g_st = thr_status[grant_tid*3 +: 3];

  always_comb begin
    seen = '0;
    for (int p = 0; p < NUM_THR; p++) seen[order_flat[p*TID_W +: TID_W]] = 1'b1;
  end

  assert_rr_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (NUM_THR > 1 && grant_valid && sel_mode == 2'd1) |->
      (thr_active[grant_tid] && head_ready[grant_tid] && g_st <= 3'd1));

  assert_old_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (NUM_THR > 1 && grant_valid && sel_mode != 2'd1) |->
      (thr_active[grant_tid] && head_ready[grant_tid] && !rob_empty[grant_tid]));

  assert_bad_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (g_st != 3'd2 && g_st < 3'd4));

  assert_none_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (grant_tid == '0));

  assert_order_perm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == NUM_THR);

  assert_order_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_valid && grant_ready && sel_mode == 2'd1) |=> $stable(order_flat));

endmodule

bind thr_retire_sel thr_retire_sel_chk #(
  .NUM_THR (NUM_THR),
  .SEQ_W   (SEQ_W),
  .TID_W   (TID_W)
) u_chk (.*);

// File: tb/sim_thr_retire_sel.sv
module sim_thr_retire_sel;

  localparam int N  = 4;
  localparam int SW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      sel_mode = 2'd1;
  logic [N-1:0]    thr_active = '0;
  logic [3*N-1:0]  thr_status = '0;
  logic [N-1:0]    rob_empty = '1;
  logic [N-1:0]    head_ready = '0;
  logic [SW*N-1:0] head_seq = '0;
  logic            grant_valid;
  logic [1:0]      grant_tid;
  logic            grant_ready = 1'b0;

  logic       s_active = 1'b0;
  logic [2:0] s_status = 3'd0;
  logic       s_empty = 1'b1;
  logic       s_ready = 1'b0;
  logic       s_valid;
  logic [0:0] s_tid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  bit act[N];
  int st[N];
  bit emp[N];
  bit rdy[N];
  int sq[N];
  int ord[N];

  always #2 clk = ~clk;

  thr_retire_sel #(.NUM_THR(N), .SEQ_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_mode(sel_mode), .thr_active(thr_active),
    .thr_status(thr_status), .rob_empty(rob_empty), .head_ready(head_ready),
    .head_seq(head_seq), .grant_valid(grant_valid), .grant_tid(grant_tid),
    .grant_ready(grant_ready)
  );

  thr_retire_sel #(.NUM_THR(1), .SEQ_W(SW)) u1 (
    .clk(clk), .rst_n(rst_n), .sel_mode(sel_mode), .thr_active(s_active),
    .thr_status(s_status), .rob_empty(s_empty), .head_ready(s_ready),
    .head_seq(8'd0), .grant_valid(s_valid), .grant_tid(s_tid),
    .grant_ready(1'b1)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic void ref_pick(output bit v, output int t);
    v = 0; t = 0;
    if (sel_mode == 2'd1) begin
      for (int p = 0; p < N; p++) begin
        int k = ord[p];
        if (!v && act[k] && rdy[k] && (st[k] == 0 || st[k] == 1)) begin
          v = 1; t = k;
        end
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (act[i] && rdy[i] && !emp[i] && (st[i] <= 1 || st[i] == 3) &&
            (!v || sq[i] < sq[t])) begin
          v = 1; t = i;
        end
      end
    end
  endfunction

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      thr_active[i] = act[i];
      thr_status[i*3 +: 3] = 3'(st[i]);
      rob_empty[i] = emp[i];
      head_ready[i] = rdy[i];
      head_seq[i*SW +: SW] = SW'(sq[i]);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    sel_mode = m;
    grant_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) ord[i] = i;
  endtask

  // one cycle: drive at falling edge, check before rising edge, update model
  task automatic step(input string req, input bit take);
    bit v; int t; int p;
    @(negedge clk);
    drive();
    grant_ready = take;
    #1;
    ref_pick(v, t);
    chk(req, int'(grant_valid), int'(v));
    chk(req, int'(grant_tid), t);
    if (v && take && sel_mode == 2'd1) begin
      p = 0;
      for (int i = 0; i < N; i++) if (ord[i] == t) p = i;
      for (int i = p; i < N - 1; i++) ord[i] = ord[i+1];
      ord[N-1] = t;
    end
  endtask

  task automatic all_ok();
    for (int i = 0; i < N; i++) begin
      act[i] = 1; st[i] = 1; emp[i] = 0; rdy[i] = 1; sq[i] = 10 + i;
    end
  endtask

  task automatic randomize_inputs();
    for (int i = 0; i < N; i++) begin
      act[i] = ($urandom % 4) != 0;
      st[i]  = $urandom % 8;
      if (st[i] > 4 && ($urandom % 2) == 0) st[i] = $urandom % 2;
      emp[i] = ($urandom % 5) == 0;
      rdy[i] = ($urandom % 3) != 0;
      sq[i]  = $urandom % 256;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));

    // R4: reset order 0..3, all eligible -> thread 0 first
    do_reset(2'd1);
    all_ok();
    step("R4", 1'b0);
    step("R4", 1'b0);
    // R3: taken grants walk through 0,1,2,3 then wrap
    for (int k = 0; k < 5; k++) step("R3", 1'b1);
    // R3: no rotation while ready is low
    step("R3", 1'b0);
    step("R3", 1'b0);
    // R9/R2: trap, squash and fetch-trap states blocked in round-robin
    all_ok(); st[0] = 2; st[1] = 4; st[2] = 3; st[3] = 6;
    step("R9", 1'b1);
    // R2: readiness and activity gate eligibility
    all_ok(); rdy[0] = 0; act[1] = 0; rdy[2] = 0;
    step("R2", 1'b1);
    step("R2", 1'b1);
    // R7: nothing eligible
    all_ok(); for (int i = 0; i < N; i++) rdy[i] = 0;
    step("R7", 1'b1);
    for (int k = 0; k < 3000; k++) begin
      randomize_inputs();
      step("R2", ($urandom % 4) != 0);
    end

    // R5/R1: oldest-first and the modes sharing it
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      do_reset(2'(m));
      all_ok(); sq[2] = 3;
      step("R5", 1'b1);
      // R5: fetch-trap pending allowed, empty buffer blocks
      all_ok(); st[1] = 3; sq[1] = 1; emp[2] = 1; sq[2] = 0;
      step("R5", 1'b1);
      // R6: equal ages pick lower index
      all_ok(); sq[1] = 5; sq[3] = 5; sq[0] = 9; sq[2] = 9;
      step("R6", 1'b1);
      // R9: squashing thread never wins
      all_ok(); st[0] = 4; sq[0] = 0; st[1] = 2; sq[1] = 0;
      step("R9", 1'b1);
      for (int k = 0; k < 1500; k++) begin
        randomize_inputs();
        step("R1", 1'b1);
      end
    end

    // R8: single-thread build ignores readiness and emptiness
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      s_active = ($urandom % 4) != 0;
      s_status = 3'($urandom % 8);
      s_empty  = $urandom % 2;
      s_ready  = $urandom % 2;
      #1;
      chk("R8", int'(s_valid),
          int'(s_active && (s_status <= 3'd1 || s_status == 3'd3)));
      chk("R8", int'(s_tid), 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule